// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block sits on an MDIO bus as a slave device and opens a 32-bit register space, addressed by a 19-bit byte address, to a management host that can only issue 16-bit MDIO reads and writes. The two upper bits of the PHY address field in each frame choose how the frame is treated. One mode loads a page register. One mode reaches a register inside the current 512-byte page. The remaining codes belong to ordinary PHYs on the same bus, and the bridge stays silent for them.

A register access is built from the page register, the three low PHY address bits and the five register address bits. The lowest register address bit picks the 16-bit half of the addressed 32-bit word. Software reaches a register as two MDIO frames, low half first. The bridge combines the two halves of a write into a single 32-bit write. For a read it takes one snapshot of the word, so both halves come from the same fetch. The register-file side is a request/acknowledge port carrying a word-aligned byte address.

MDC and MDIO are sampled with the system clock. The bridge acts on each MDC rising edge, and any bit it drives changes immediately after that edge.

Top module: `mdio_paged_bridge`

## Requirements
- R1: Only PHY address bits 4:3 equal to 2'b11 (page) or 2'b10 (register) are acted on. For codes 2'b00 and 2'b01 the bridge never drives MDIO, never issues a register-file request and leaves the page register unchanged.
- R2: A page-mode write (opcode 2'b01) loads write-data bits 9:0 into the page register and ignores bits 15:10. Reset sets the page to 0. The page supplies byte-address bits 18:9.
- R3: A register-mode access uses byte address {page, PHY address bits 2:0, register address bits 4:0, 1'b0}. Register address bit 0 selects the high (1) or low (0) half. The register-file address is the word address with bits 1:0 cleared.
- R4: A low-half write produces no register-file request. The following high-half write to the same word issues exactly one 32-bit write with data {high half, low half}.
- R5: A high-half write that does not follow a low-half write to the same word issues no request. Any high-half write discards the latched low half.
- R6: A low-half read (opcode 2'b10) issues one register-file read and returns bits 15:0. A following high-half read of the same word issues no request and returns bits 31:16 of that same snapshot.
- R7: A high-half read of a word that has no valid snapshot issues a fresh register-file read and returns bits 31:16.
- R8: The bridge enables its MDIO driver only on owned register-mode reads. It drives 0 in the second turnaround bit and then the 16 data bits, for exactly 17 MDC periods, and never while the host drives.
- R9: After reset no request is pending. A request stays asserted with stable address, direction and data until it is acknowledged.
- R10: Page-mode reads are not answered: no MDIO drive and no register-file request.
- R11: Read data is sent most significant bit first. Each bit is valid from just after one MDC rising edge until the next, so the host samples it on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | MDIO clock, synchronous to clk |
| mdioIn | input | 1 | Resolved MDIO line value |
| mdioOut | output | 1 | Value driven onto MDIO when enabled |
| mdioOe | output | 1 | MDIO driver enable |
| rfReq | output | 1 | Register-file request, held until acknowledged |
| rfWe | output | 1 | Request is a write |
| rfAddr | output | 19 | Word-aligned byte address |
| rfWdata | output | 32 | Write data |
| rfRdata | input | 32 | Read data, valid with rfAck |
| rfAck | input | 1 | Register-file acknowledge |

## Verification
The assertions take MDC and MDIO to be synchronous to clk, with each MDC half period lasting several clk cycles. They also take a register-file read to be acknowledged well within one MDC period, and successive frames never to overlap a pending register-file access. The bench drives MDC with eight clk cycles per half period and acknowledges every request one cycle after it appears. It changes host bits only while MDC is low and releases the line for the turnaround and data phases of every read, so these conditions always hold.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  localparam logic [1:0] MODE_PAGE = 2'b11;
  localparam logic [1:0] MODE_REG  = 2'b10;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;

  typedef struct packed {
    logic shiftIn;   // sample one data bit
    logic capHdr;    // capture address fields of the header
    logic pageWr;    // commit page register
    logic regWr;     // register-mode half write complete
    logic regRd;     // register-mode read: fetch if needed
    logic loadOut;   // load read half into output shifter
    logic shiftOut;  // advance output shifter
  } bridge_strobe_t;

endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           mdc,
  input  logic           mdioIn,
  output bridge_strobe_t stb,
  output logic [7:0]     addrBits,
  output logic           mdioOe
);

  localparam int CNT_W    = $clog2(DATA_W);
  localparam int HDR_BITS = 13;  // ST low bit, OP, PHY, REG

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_TURN, ST_DATA} phase_t;

  phase_t                phase;
  logic                  mdcQ;
  logic                  mdcRise;
  logic                  prevBit;
  logic [CNT_W-1:0]      bitCnt;
  logic [HDR_BITS-2:0]   hdrBits;
  logic [HDR_BITS-1:0]   hdrWord;
  logic                  hdrLast;
  logic                  dataLast;
  logic                  ownRd;
  logic                  ownWr;
  logic                  isPage;
  logic                  frameRead;
  logic                  frameWrite;
  logic                  framePage;

  assign mdcRise  = mdc & ~mdcQ;
  assign hdrWord  = {hdrBits, mdioIn};
  assign addrBits = hdrWord[7:0];
  assign hdrLast  = (bitCnt == CNT_W'(HDR_BITS - 1));
  assign dataLast = (bitCnt == CNT_W'(DATA_W - 1));

  assign isPage = (hdrWord[9:8] == MODE_PAGE);
  assign ownRd  = hdrWord[12] && (hdrWord[11:10] == OP_READ) && (hdrWord[9:8] == MODE_REG);
  assign ownWr  = hdrWord[12] && (hdrWord[11:10] == OP_WRITE) &&
                  ((hdrWord[9:8] == MODE_REG) || isPage);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcQ       <= 1'b0;
      prevBit    <= 1'b1;
      phase      <= ST_IDLE;
      bitCnt     <= '0;
      hdrBits    <= '0;
      mdioOe     <= 1'b0;
      frameRead  <= 1'b0;
      frameWrite <= 1'b0;
      framePage  <= 1'b0;
    end else begin
      mdcQ <= mdc;
      if (mdcRise) begin
        prevBit <= mdioIn;
        unique case (phase)
          ST_IDLE: begin
            if (prevBit && !mdioIn) begin
              phase  <= ST_HDR;
              bitCnt <= '0;
            end
          end
          ST_HDR: begin
            hdrBits <= hdrWord[HDR_BITS-2:0];
            bitCnt  <= bitCnt + 1'b1;
            if (hdrLast) begin
              phase      <= ST_TURN;
              bitCnt     <= '0;
              frameRead  <= ownRd;
              frameWrite <= ownWr;
              framePage  <= isPage;
            end
          end
          ST_TURN: begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == '0) begin
              if (frameRead) mdioOe <= 1'b1;
            end else begin
              phase  <= ST_DATA;
              bitCnt <= '0;
            end
          end
          ST_DATA: begin
            bitCnt <= bitCnt + 1'b1;
            if (dataLast) begin
              phase      <= ST_IDLE;
              bitCnt     <= '0;
              mdioOe     <= 1'b0;
              frameRead  <= 1'b0;
              frameWrite <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.capHdr   = mdcRise && (phase == ST_HDR) && hdrLast;
    stb.regRd    = mdcRise && (phase == ST_TURN) && (bitCnt == '0) && frameRead;
    stb.loadOut  = mdcRise && (phase == ST_TURN) && (bitCnt != '0) && frameRead;
    stb.shiftIn  = mdcRise && (phase == ST_DATA);
    stb.shiftOut = stb.shiftIn && frameRead;
    stb.pageWr   = stb.shiftIn && dataLast && frameWrite && framePage;
    stb.regWr    = stb.shiftIn && dataLast && frameWrite && !framePage;
  end

  AST_OE_OWNED_READ: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> frameRead) else $error("driver on outside an owned read"); // R8

  AST_OE_AT_MDC_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !mdcRise |=> $stable(mdioOe)) else $error("driver enable moved away from MDC edge"); // R11

  AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    frameRead |-> !frameWrite) else $error("frame both read and write"); // R1

endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  bridge_strobe_t      stb,
  input  logic [7:0]          addrBits,
  input  logic                mdioIn,
  input  logic                rfAck,
  input  logic [2*DATA_W-1:0] rfRdata,
  output logic                outBit,
  output logic                rfReq,
  output logic                rfWe,
  output logic [PAGE_W+8:0]   rfAddr,
  output logic [2*DATA_W-1:0] rfWdata
);

  localparam int REG_W  = 2 * DATA_W;
  localparam int ADDR_W = PAGE_W + 9;

  logic [PAGE_W-1:0] page;
  logic [2:0]        phyLow;
  logic [4:0]        regLo;
  logic [DATA_W-2:0] dataShift;
  logic [DATA_W-1:0] newWord;
  logic [ADDR_W-1:0] wordAddr;
  logic              half;
  logic [DATA_W-1:0] lowData;
  logic [ADDR_W-1:0] lowAddr;
  logic              lowValid;
  logic [REG_W-1:0]  snap;
  logic [ADDR_W-1:0] snapAddr;
  logic              snapValid;
  logic              snapHit;
  logic [DATA_W-1:0] outShift;

  assign newWord  = {dataShift, mdioIn};
  assign wordAddr = {page, phyLow, regLo[4:1], 2'b00};
  assign half     = regLo[0];
  assign snapHit  = snapValid && (snapAddr == wordAddr);
  assign outBit   = outShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      page      <= '0;
      phyLow    <= '0;
      regLo     <= '0;
      dataShift <= '0;
      lowData   <= '0;
      lowAddr   <= '0;
      lowValid  <= 1'b0;
      snap      <= '0;
      snapAddr  <= '0;
      snapValid <= 1'b0;
      outShift  <= '0;
      rfReq     <= 1'b0;
      rfWe      <= 1'b0;
      rfAddr    <= '0;
      rfWdata   <= '0;
    end else begin
      if (stb.capHdr) begin
        phyLow <= addrBits[7:5];
        regLo  <= addrBits[4:0];
      end
      if (stb.shiftIn) dataShift <= newWord[DATA_W-2:0];
      if (stb.pageWr)  page <= newWord[PAGE_W-1:0];

      if (stb.regWr) begin
        if (!half) begin
          lowData  <= newWord;
          lowAddr  <= wordAddr;
          lowValid <= 1'b1;
        end else begin
          lowValid <= 1'b0;
          if (lowValid && (lowAddr == wordAddr)) begin
            rfReq     <= 1'b1;
            rfWe      <= 1'b1;
            rfAddr    <= wordAddr;
            rfWdata   <= {newWord, lowData};
            snapValid <= 1'b0;
          end
        end
      end

      if (stb.regRd) begin
        outShift <= '0;
        if (!(half && snapHit)) begin
          rfReq     <= 1'b1;
          rfWe      <= 1'b0;
          rfAddr    <= wordAddr;
          snapValid <= 1'b0;
        end
      end

      if (rfReq && rfAck) begin
        rfReq <= 1'b0;
        if (!rfWe) begin
          snap      <= rfRdata;
          snapAddr  <= rfAddr;
          snapValid <= 1'b1;
        end
      end

      if (stb.loadOut)
        outShift <= half ? snap[REG_W-1:DATA_W] : snap[DATA_W-1:0];
      else if (stb.shiftOut)
        outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pageWr |=> $stable(page)) else $error("page changed without page write"); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rfReq && !rfAck |=> rfReq && $stable(rfAddr) && $stable(rfWe) && $stable(rfWdata))
    else $error("request dropped or changed before acknowledge"); // R9

  AST_WRITE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rfReq) && rfWe |-> $past(stb.regWr) && half)
    else $error("write issued without a high-half write"); // R4

  AST_READ_FROM_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rfReq) && !rfWe |-> $past(stb.regRd))
    else $error("read issued outside a register read"); // R6

endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mdc,
  input  logic                mdioIn,
  output logic                mdioOut,
  output logic                mdioOe,
  output logic                rfReq,
  output logic                rfWe,
  output logic [PAGE_W+8:0]   rfAddr,
  output logic [2*DATA_W-1:0] rfWdata,
  input  logic [2*DATA_W-1:0] rfRdata,
  input  logic                rfAck
);

  bridge_strobe_t stb;
  logic [7:0]     addrBits;
  logic           outBit;

  mdio_bridge_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mdc      (mdc),
    .mdioIn   (mdioIn),
    .stb      (stb),
    .addrBits (addrBits),
    .mdioOe   (mdioOe)
  );

  mdio_bridge_dp #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addrBits (addrBits),
    .mdioIn   (mdioIn),
    .rfAck    (rfAck),
    .rfRdata  (rfRdata),
    .outBit   (outBit),
    .rfReq    (rfReq),
    .rfWe     (rfWe),
    .rfAddr   (rfAddr),
    .rfWdata  (rfWdata)
  );

  assign mdioOut = mdioOe & outBit;

endmodule

// File: tb/test_mdio_paged_bridge.sv
module test_mdio_paged_bridge;

  localparam logic [1:0] RD = 2'b10;
  localparam logic [1:0] WR = 2'b01;

  logic        clk = 1'b0;
  logic        rstN;
  logic        mdc;
  logic        masterOe;
  logic        masterBit;
  wire         busBit;
  logic        mdioOut;
  logic        mdioOe;
  logic        rfReq;
  logic        rfWe;
  logic [18:0] rfAddr;
  logic [31:0] rfWdata;
  logic [31:0] rfRdata;
  logic        rfAck;

  int checks = 0;
  int fails = 0;
  int reqCnt = 0;
  int fetchCnt = 0;
  int oeCount = 0;
  int clashCount = 0;
  logic [18:0] lastAddr = '0;
  logic        lastWe = 1'b0;
  logic [31:0] lastWdata = '0;

  assign busBit = masterOe ? masterBit : (mdioOe ? mdioOut : 1'b1);

  always #4 clk = ~clk;

  mdio_paged_bridge i_mdio_paged_bridge (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(busBit),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .rfReq(rfReq), .rfWe(rfWe), .rfAddr(rfAddr), .rfWdata(rfWdata),
    .rfRdata(rfRdata), .rfAck(rfAck)
  );

  function automatic logic [31:0] rdFn(logic [18:0] a, int n);
    return {a[17:2], a[15:0] ^ 16'hC3A5} + 32'(n) * 32'h00010001;
  endfunction

  function automatic logic [18:0] wordOf(logic [9:0] pg, logic [4:0] phy, logic [4:0] r);
    return {pg, phy[2:0], r[4:1], 2'b00};
  endfunction

  // register-file model: acknowledge one cycle after a request
  initial begin
    rfAck = 1'b0;
    rfRdata = '0;
    forever begin
      @(posedge clk);
      if (rfReq === 1'b1 && !rfAck) begin
        rfAck   <= 1'b1;
        rfRdata <= rdFn(rfAddr, fetchCnt);
        reqCnt++;
        lastAddr  = rfAddr;
        lastWe    = rfWe;
        lastWdata = rfWdata;
        if (!rfWe) fetchCnt++;
      end else begin
        rfAck <= 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mdioOe === 1'b1) oeCount++;
      if (mdioOe === 1'b1 && masterOe) clashCount++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic s);
    @(negedge clk);
    mdc = 1'b0;
    masterBit = b;
    repeat (7) @(negedge clk);
    s = busBit;
    mdc = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] regA,
                       input logic [15:0] wd, output logic [15:0] rd, output logic taOk);
    logic s;
    logic s0;
    logic s1;
    oeCount = 0;
    rd = '0;
    masterOe = 1'b1;
    for (int i = 0; i < 32; i++) sendBit(1'b1, s);
    sendBit(1'b0, s);
    sendBit(1'b1, s);
    for (int i = 1; i >= 0; i--) sendBit(op[i], s);
    for (int i = 4; i >= 0; i--) sendBit(phy[i], s);
    for (int i = 4; i >= 0; i--) sendBit(regA[i], s);
    if (op == WR) begin
      sendBit(1'b1, s);
      sendBit(1'b0, s);
      for (int i = 15; i >= 0; i--) sendBit(wd[i], s);
      taOk = 1'b0;
    end else begin
      masterOe = 1'b0;
      sendBit(1'b1, s0);
      sendBit(1'b1, s1);
      for (int i = 15; i >= 0; i--) sendBit(1'b1, rd[i]);
      taOk = (s0 == 1'b1) && (s1 == 1'b0);
    end
    masterOe = 1'b1;
    sendBit(1'b1, s);
  endtask

  task automatic tResetState();
    chk("R8 driver off after reset", 32'(mdioOe), 32'd0);
    chk("R9 no request after reset", 32'(rfReq), 32'd0);
  endtask

  task automatic tDefaultPageRead();
    logic [15:0] rd;
    logic ta;
    int n0 = reqCnt;
    int f0 = fetchCnt;
    logic [18:0] w = wordOf(10'd0, 5'b10011, 5'b00100);
    frame(RD, 5'b10011, 5'b00100, 16'h0, rd, ta);
    chk("R9 one fetch for low read", 32'(reqCnt - n0), 32'd1);
    chk("R2 reset page is zero", 32'(lastAddr), 32'(w));
    chk("R11 low half MSB first", 32'(rd), 32'(rdFn(w, f0) & 32'hFFFF));
    chk("R8 turnaround Z then 0", 32'(ta), 32'd1);
    chk("R8 drive lasts 17 MDC periods", 32'(oeCount), 32'd272);
  endtask

  task automatic tPageAndWrite();
    logic [15:0] rd;
    logic ta;
    int n0;
    frame(WR, 5'b11000, 5'b00000, 16'hFEAB, rd, ta);
    n0 = reqCnt;
    frame(WR, 5'b10101, 5'b01100, 16'h1234, rd, ta);
    chk("R4 low write makes no request", 32'(reqCnt - n0), 32'd0);
    frame(WR, 5'b10101, 5'b01101, 16'hABCD, rd, ta);
    chk("R4 high write commits once", 32'(reqCnt - n0), 32'd1);
    chk("R4 commit is a write", 32'(lastWe), 32'd1);
    chk("R4 joined write data", lastWdata, 32'hABCD1234);
    chk("R3 address from page and fields", 32'(lastAddr), 32'(wordOf(10'h2AB, 5'b10101, 5'b01100)));
  endtask

  task automatic tOrphanHigh();
    logic [15:0] rd;
    logic ta;
    int n0 = reqCnt;
    frame(WR, 5'b10010, 5'b10011, 16'h5555, rd, ta);
    chk("R5 lone high write dropped", 32'(reqCnt - n0), 32'd0);
    frame(WR, 5'b10010, 5'b00010, 16'h1111, rd, ta);
    frame(WR, 5'b10010, 5'b00101, 16'h2222, rd, ta);
    chk("R5 high write to other word dropped", 32'(reqCnt - n0), 32'd0);
    frame(WR, 5'b10010, 5'b00011, 16'h3333, rd, ta);
    chk("R5 low latch discarded by high write", 32'(reqCnt - n0), 32'd0);
  endtask

  task automatic tSnapshot();
    logic [15:0] rd;
    logic ta;
    int n0 = reqCnt;
    int f0 = fetchCnt;
    logic [18:0] w = wordOf(10'h2AB, 5'b10110, 5'b01000);
    frame(RD, 5'b10110, 5'b01000, 16'h0, rd, ta);
    chk("R6 low read fetches", 32'(reqCnt - n0), 32'd1);
    chk("R6 low read address", 32'(lastAddr), 32'(w));
    chk("R6 low half data", 32'(rd), 32'(rdFn(w, f0) & 32'hFFFF));
    frame(RD, 5'b10110, 5'b01001, 16'h0, rd, ta);
    chk("R6 high read uses snapshot", 32'(reqCnt - n0), 32'd1);
    chk("R6 high half from same snapshot", 32'(rd), rdFn(w, f0) >> 16);
  endtask

  task automatic tFreshHigh();
    logic [15:0] rd;
    logic ta;
    int n0 = reqCnt;
    int f0 = fetchCnt;
    logic [18:0] w = wordOf(10'h2AB, 5'b10001, 5'b11111);
    frame(RD, 5'b10001, 5'b11111, 16'h0, rd, ta);
    chk("R7 high read without snapshot fetches", 32'(reqCnt - n0), 32'd1);
    chk("R7 fetch address", 32'(lastAddr), 32'(w));
    chk("R7 upper half returned", 32'(rd), rdFn(w, f0) >> 16);
  endtask

  task automatic tBypass();
    logic [15:0] rd;
    logic ta;
    int n0 = reqCnt;
    frame(RD, 5'b00010, 5'b00110, 16'h0, rd, ta);
    chk("R1 mode 0 read not driven", 32'(oeCount), 32'd0);
    frame(RD, 5'b01010, 5'b00110, 16'h0, rd, ta);
    chk("R1 mode 1 read not driven", 32'(oeCount), 32'd0);
    frame(WR, 5'b00000, 5'b00000, 16'h03FF, rd, ta);
    chk("R1 bypass frames make no request", 32'(reqCnt - n0), 32'd0);
    frame(RD, 5'b10000, 5'b00000, 16'h0, rd, ta);
    chk("R1 bypass write leaves page", 32'(lastAddr), 32'(wordOf(10'h2AB, 5'b10000, 5'b00000)));
  endtask

  task automatic tPageRead();
    logic [15:0] rd;
    logic ta;
    int n0 = reqCnt;
    frame(RD, 5'b11000, 5'b00000, 16'h0, rd, ta);
    chk("R10 page read not driven", 32'(oeCount), 32'd0);
    chk("R10 page read makes no request", 32'(reqCnt - n0), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mdc = 1'b0;
    masterOe = 1'b1;
    masterBit = 1'b1;
    rstN = 1'b1;
    #2 rstN = 1'b0;
    repeat (5) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tDefaultPageRead();
    tPageAndWrite();
    tOrphanHigh();
    tSnapshot();
    tFreshHigh();
    tBypass();
    tPageRead();
    chk("R8 never drives with host", 32'(clashCount), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule